// File: doc/BRIEF.md
# SPI Command Engine

This block is a register-programmed SPI master for short command/response exchanges with serial flash style devices. Software fills in a command byte, a count of bytes to send after it and a count of bytes to collect back, places the outgoing bytes in a small byte store, and then sets a start bit. The engine pulls one chip-select line low and shifts out the command byte. It then shifts out the outgoing bytes and clocks in the requested number of reply bytes. A busy flag in the control register stays set until the whole exchange is over.

The command byte lives in its own register and never occupies a store entry. Outgoing bytes are taken from store index 0 upward. Reply bytes are written back into the same store starting at the index equal to the send count, so software finds its request and the reply side by side. The store can be reached in two ways. One is a direct byte window. The other is a single data port whose read returns the entry at an internal pointer and moves that pointer on by one. A control bit returns the pointer to zero.

The link runs SPI mode 0, most significant bit first. SCLK is the system clock divided by 2*SCLK_HALF.

Top module: `spi_cmd_engine`

Register map (byte addresses): 0x00 control, 0x01 command byte, 0x02 send count, 0x03 reply count, 0x04 data port, 0x40 to 0x40+FIFO_DEPTH-1 store window. Control bits: bit 0 start (write 1), bit 1 pointer clear (write 1, always reads 0), bit 2 busy (read only), bits 5:4 chip-select number. All other addresses and bits read 0.

## Requirements
- R1: After a start, the first byte on MOSI is the command register value, sent most significant bit first. No store entry is consumed for it.
- R2: After the command byte, MOSI carries the send-count number of bytes, taken from store indices 0, 1, 2 and so on in that order.
- R3: Writing 1 to control bit 0 while idle starts an exchange. Busy (control bit 2) reads 1 from the next cycle for exactly 2*SCLK_HALF*(8*(1+send+reply)+1) cycles and then reads 0.
- R4: Reply byte i (counting from 0) is stored at store index send+i. It can be read back through the window at 0x40+send+i.
- R5: With a reply count of 0, the exchange ends right after the last sent byte: exactly 8*(1+send) SCLK pulses occur.
- R6: MOSI is 0 for every bit of the reply phase.
- R7: Control bits 5:4 choose which of the four CS_n lines is used, and no other line ever goes low. That line goes low once, at the start, and stays low until the last bit. It then sits high for 2*SCLK_HALF cycles before busy clears.
- R8: SCLK is low whenever all CS_n are high. Each SCLK level lasts exactly SCLK_HALF cycles, and the first rising edge comes SCLK_HALF cycles after CS_n falls. MISO is sampled on rising edges.
- R9: A read of the data port returns the store entry at the internal pointer and advances the pointer by one. Writing 1 to control bit 1 returns the pointer to 0.
- R10: While busy, writes to the command, count, store-window and control registers are ignored. This includes a second start and a chip-select change.
- R11: Control bit 1 clears itself and always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed only for the data port side effect) |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The bench builds the block with SCLK_HALF=2, FIFO_DEPTH=70 and NCS=4. The short divider keeps even a full-store exchange (64 bytes sent, 6 returned, 71 bytes on the wire) to a few thousand cycles. The default depth means the last reply byte lands exactly on the final store index. An even half period of 2 still separates the setup phase, the bit phase and the tail gap by whole cycles, so off-by-one timing in the divider or the gap counter shows up in the busy length and in the measured SCLK half periods.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int IDX_W = 9;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_OPC  = 8'h01;
  localparam logic [7:0] A_TXC  = 8'h02;
  localparam logic [7:0] A_RXC  = 8'h03;
  localparam logic [7:0] A_PORT = 8'h04;
  localparam logic [7:0] A_WIN  = 8'h40;

  localparam int B_EXEC = 0;
  localparam int B_CLR  = 1;
  localparam int B_BUSY = 2;
  localparam int B_CS   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_st_t;

  // index of the final byte on the wire (command byte is index 0)
  function automatic logic [IDX_W-1:0] last_index(input logic [7:0] tx, input logic [7:0] rx);
    return IDX_W'(tx) + IDX_W'(rx);
  endfunction

  // data-port pointer step with wrap at the store depth
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p, input int depth);
    return (int'(p) >= depth - 1) ? '0 : p + 1'b1;
  endfunction
endpackage

// File: rtl/spi_cmd_divider.sv
module spi_cmd_divider #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo import spi_cmd_pkg::*; #(
  parameter int DEPTH = 70
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  input  logic [IDX_W-1:0] ra_c,
  output logic [7:0]       rd_a,
  output logic [7:0]       rd_b,
  output logic [7:0]       rd_c
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) < DEPTH) mem_q[waddr[AW-1:0]] <= wdata;
  end

  assign rd_a = (int'(ra_a) < DEPTH) ? mem_q[ra_a[AW-1:0]] : 8'h00;
  assign rd_b = (int'(ra_b) < DEPTH) ? mem_q[ra_b[AW-1:0]] : 8'h00;
  assign rd_c = (int'(ra_c) < DEPTH) ? mem_q[ra_c[AW-1:0]] : 8'h00;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter import spi_cmd_pkg::*; #(
  parameter int HALF  = 4,
  parameter int DEPTH = 70,
  parameter int NCS   = 4,
  parameter int CSW   = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [7:0]       tx_cnt,
  input  logic [7:0]       rx_cnt,
  input  logic [CSW-1:0]   cs_sel,
  input  logic             tick,
  input  logic             miso,
  input  logic [7:0]       fifo_rdata,
  output logic [IDX_W-1:0] fifo_raddr,
  output logic             fifo_we,
  output logic [IDX_W-1:0] fifo_waddr,
  output logic [7:0]       fifo_wdata,
  output logic             busy,
  output logic             run,
  output logic             done_evt,
  output logic             rx_phase,
  output logic             sclk,
  output logic             mosi,
  output logic [NCS-1:0]   cs_n
);
  localparam int GAP_LEN = 2 * HALF;
  localparam int GW = $clog2(GAP_LEN) + 1;

  eng_st_t          st_q;
  logic [7:0]       out_q, in_q, tx_q;
  logic [IDX_W-1:0] byte_q, last_q;
  logic [2:0]       bit_q;
  logic [GW-1:0]    gap_q;
  logic             sclk_q;
  logic [NCS-1:0]   csn_q;

  wire rise_evt = tick && (st_q == ST_SHIFT) && !sclk_q;
  wire fall_evt = tick && (st_q == ST_SHIFT) && sclk_q;
  wire byte_end = fall_evt && (bit_q == 3'd0);
  wire in_rx    = byte_q > IDX_W'(tx_q);
  // next wire byte is byte_q+1; while it is a send byte it comes from store[byte_q]
  wire [7:0] nxt_out = (byte_q < IDX_W'(tx_q)) ? fifo_rdata : 8'h00;

  assign fifo_raddr = byte_q;
  assign fifo_waddr = byte_q - 1'b1;
  assign fifo_wdata = in_q;
  assign fifo_we    = byte_end && in_rx && (int'(byte_q) <= DEPTH);
  assign rx_phase   = (st_q == ST_SHIFT) && in_rx;
  assign done_evt   = (st_q == ST_GAP) && (gap_q == GW'(GAP_LEN - 1));
  assign busy       = st_q != ST_IDLE;
  assign run        = st_q == ST_SHIFT;
  assign sclk       = sclk_q;
  assign mosi       = (st_q == ST_SHIFT) ? out_q[7] : 1'b0;
  assign cs_n       = csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      out_q  <= '0;
      in_q   <= '0;
      tx_q   <= '0;
      byte_q <= '0;
      last_q <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      sclk_q <= 1'b0;
      csn_q  <= '1;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_SHIFT;
          out_q  <= opcode;
          tx_q   <= tx_cnt;
          last_q <= last_index(tx_cnt, rx_cnt);
          byte_q <= '0;
          bit_q  <= 3'd7;
          sclk_q <= 1'b0;
          csn_q  <= ~(NCS'(1) << cs_sel);
        end
        ST_SHIFT: begin
          if (rise_evt) begin
            sclk_q <= 1'b1;
            in_q   <= {in_q[6:0], miso};
          end
          if (fall_evt) begin
            sclk_q <= 1'b0;
            if (bit_q != 3'd0) begin
              bit_q <= bit_q - 1'b1;
              out_q <= {out_q[6:0], 1'b0};
            end else if (byte_q == last_q) begin
              st_q  <= ST_GAP;
              csn_q <= '1;
              gap_q <= '0;
            end else begin
              byte_q <= byte_q + 1'b1;
              bit_q  <= 3'd7;
              out_q  <= nxt_out;
            end
          end
        end
        ST_GAP: begin
          if (done_evt) st_q <= ST_IDLE;
          else          gap_q <= gap_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_cmd_pkg::*; #(
  parameter int SCLK_HALF  = 4,
  parameter int FIFO_DEPTH = 70,
  parameter int NCS        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [7:0]       opc_q, txc_q, rxc_q;
  logic [CSW-1:0]   cs_q;
  logic [IDX_W-1:0] ptr_q;
  logic             busy, tick, run, done_evt, rx_phase;
  logic             eng_we;
  logic [IDX_W-1:0] eng_waddr, eng_raddr;
  logic [7:0]       eng_wdata, eng_rdata, win_rd, port_rd;

  // named bus events
  wire              wr_idle     = reg_wr && !busy;
  wire              hit_ctrl    = reg_addr == A_CTRL;
  wire              start_evt   = wr_idle && hit_ctrl && reg_wdata[B_EXEC];
  wire              clr_evt     = wr_idle && hit_ctrl && reg_wdata[B_CLR];
  wire              port_rd_evt = reg_rd && (reg_addr == A_PORT);
  wire [IDX_W-1:0]  win_off     = IDX_W'(reg_addr) - IDX_W'(A_WIN);
  wire              in_win      = (reg_addr >= A_WIN) && (int'(win_off) < FIFO_DEPTH);
  wire              bus_fifo_we = wr_idle && in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
      txc_q <= '0;
      rxc_q <= '0;
      cs_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_idle) begin
        case (reg_addr)
          A_OPC:   opc_q <= reg_wdata;
          A_TXC:   txc_q <= reg_wdata;
          A_RXC:   rxc_q <= reg_wdata;
          A_CTRL:  cs_q  <= reg_wdata[B_CS +: CSW];
          default: ;
        endcase
      end
      if (clr_evt)          ptr_q <= '0;
      else if (port_rd_evt) ptr_q <= wrap_inc(ptr_q, FIFO_DEPTH);
    end
  end

  spi_cmd_divider #(.HALF(SCLK_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk),
    .we(busy ? eng_we : bus_fifo_we),
    .waddr(busy ? eng_waddr : win_off),
    .wdata(busy ? eng_wdata : reg_wdata),
    .ra_a(win_off), .ra_b(eng_raddr), .ra_c(ptr_q),
    .rd_a(win_rd), .rd_b(eng_rdata), .rd_c(port_rd)
  );

  spi_cmd_shifter #(.HALF(SCLK_HALF), .DEPTH(FIFO_DEPTH), .NCS(NCS), .CSW(CSW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt),
    .opcode(opc_q), .tx_cnt(txc_q), .rx_cnt(rxc_q),
    .cs_sel(reg_wdata[B_CS +: CSW]),
    .tick(tick), .miso(miso), .fifo_rdata(eng_rdata),
    .fifo_raddr(eng_raddr), .fifo_we(eng_we), .fifo_waddr(eng_waddr), .fifo_wdata(eng_wdata),
    .busy(busy), .run(run), .done_evt(done_evt), .rx_phase(rx_phase),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (in_win) reg_rdata = win_rd;
    else begin
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[B_BUSY]       = busy;
          reg_rdata[B_CS +: CSW]  = cs_q;
        end
        A_OPC:   reg_rdata = opc_q;
        A_TXC:   reg_rdata = txc_q;
        A_RXC:   reg_rdata = rxc_q;
        A_PORT:  reg_rdata = port_rd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           start_evt,
  input logic           done_evt,
  input logic           rx_phase,
  input logic           tick,
  input logic           sclk,
  input logic           mosi,
  input logic [NCS-1:0] cs_n
);
  assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_idle_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  assert_sclk_low_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  assert_sclk_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk));

  assert_mosi_zero_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase |-> !mosi);

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_busy_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> busy);

  assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NCS(NCS)) u_spi_cmd_engine_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_evt(start_evt), .done_evt(done_evt),
  .rx_phase(rx_phase), .tick(tick), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int DEPTH = 70;
  localparam int NCS   = 4;
  localparam logic [7:0] AD_CTRL = 8'h00, AD_OPC = 8'h01, AD_TXC = 8'h02,
                         AD_RXC = 8'h03, AD_PORT = 8'h04, AD_WIN = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [NCS-1:0] cs_n;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  spi_cmd_engine #(.SCLK_HALF(HALF), .FIFO_DEPTH(DEPTH), .NCS(NCS)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------- slave model: records MOSI bytes, returns a known stream ----------
  function automatic logic [7:0] slave_byte(input int j);
    return 8'(8'hC3 ^ (j * 7));
  endfunction

  wire cs_act = ~&cs_n;
  logic [7:0] got_q[$];
  logic [7:0] s_cur;
  int s_bit = 0;

  always @(posedge cs_act) begin
    logic [7:0] b;
    s_bit = 0;
    b = slave_byte(0);
    miso = b[7];
  end
  always @(posedge sclk) if (cs_act) begin
    s_cur = {s_cur[6:0], mosi};
    s_bit++;
    if (s_bit % 8 == 0) got_q.push_back(s_cur);
  end
  always @(negedge sclk) if (cs_act) begin
    logic [7:0] b;
    b = slave_byte(s_bit / 8);
    miso = b[7 - (s_bit % 8)];
  end

  // ---------- per-clock monitor of link timing ----------
  int cyc = 0, last_chg = 0;
  int busy_cnt, tail_cnt, cs_err, sclk_err, half_err, falls;
  logic [NCS-1:0] exp_mask = '1;
  logic prev_sclk = 1'b0, prev_cs = 1'b0;

  always @(posedge clk) begin
    cyc++;
    #3;
    if (rst_n) begin
      if (cs_n != '1 && cs_n != exp_mask) cs_err++;
      if ((&cs_n) && sclk) sclk_err++;
      if (cs_act && !prev_cs) begin falls++; last_chg = cyc; end
      if (sclk !== prev_sclk) begin
        if (cyc - last_chg != HALF) half_err++;
        last_chg = cyc;
      end
      if (reg_addr == AD_CTRL && reg_rdata[2]) begin
        busy_cnt++;
        if (&cs_n) tail_cnt++;
      end
      prev_sclk = sclk;
      prev_cs = cs_act;
    end
  end

  // ---------- helpers ----------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = AD_CTRL; reg_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = AD_CTRL;
  endtask

  task automatic wait_idle();
    do begin
      @(posedge clk);
      #4;
    end while (reg_rdata[2]);
  endtask

  logic [7:0] tx_data [DEPTH];

  task automatic run_txn(input int cs, input logic [7:0] opc, input int tx, input int rx,
                         input bit timed, input bit disturb);
    int bad;
    logic [7:0] v;
    for (int i = 0; i < tx; i++) bus_write(8'(AD_WIN + i), tx_data[i]);
    bus_write(AD_OPC, opc);
    bus_write(AD_TXC, 8'(tx));
    bus_write(AD_RXC, 8'(rx));
    exp_mask = ~(NCS'(1) << cs);
    got_q.delete();
    busy_cnt = 0; tail_cnt = 0; cs_err = 0; sclk_err = 0; half_err = 0; falls = 0;
    bus_write(AD_CTRL, 8'((cs << 4) | 1));
    if (disturb) begin
      // R10: all of these land while busy and must change nothing
      bus_write(AD_OPC, 8'hFF);
      bus_write(AD_TXC, 8'h05);
      bus_write(AD_RXC, 8'h00);
      bus_write(AD_WIN, 8'h00);
      bus_write(AD_CTRL, 8'h01);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    // R1: command byte first
    check(got_q.size() > 0 && got_q[0] == opc, "R1 command byte", got_q.size() > 0 ? int'(got_q[0]) : -1, int'(opc));
    // R3/R5: byte count on the wire
    check(got_q.size() == 1 + tx + rx, rx == 0 ? "R5 wire byte count" : "R3 wire byte count", got_q.size(), 1 + tx + rx);
    if (got_q.size() == 1 + tx + rx) begin
      bad = 0;
      for (int i = 0; i < tx; i++) if (got_q[1 + i] != tx_data[i]) bad++;
      check(bad == 0, "R2 send bytes from store", bad, 0);
      bad = 0;
      for (int i = 0; i < rx; i++) if (got_q[1 + tx + i] != 8'h00) bad++;
      check(bad == 0, "R6 MOSI zero in reply phase", bad, 0);
    end
    bad = 0;
    for (int i = 0; i < rx; i++) begin
      bus_read(8'(AD_WIN + tx + i), v);
      if (v != slave_byte(1 + tx + i)) bad++;
    end
    check(bad == 0, "R4 reply bytes at send offset", bad, 0);
    check(cs_err == 0 && falls == 1, "R7 chip select pattern", cs_err * 16 + falls, 1);
    check(half_err == 0 && sclk_err == 0, "R8 SCLK half period", half_err * 256 + sclk_err, 0);
    if (timed) begin
      check(busy_cnt == 2 * HALF * (8 * (1 + tx + rx) + 1), "R3 busy length", busy_cnt, 2 * HALF * (8 * (1 + tx + rx) + 1));
      check(tail_cnt == 2 * HALF, "R7 CS high before busy clears", tail_cnt, 2 * HALF);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(cs_n == '1, "R7 reset CS high", int'(cs_n), 15);
    check(sclk == 1'b0 && mosi == 1'b0, "R8 reset SCLK low", {sclk, mosi}, 0);
    bus_read(AD_CTRL, v);
    check(v == 8'h00, "R3 reset not busy", v, 0);

    // read opcode, no send bytes: reply starts at store index 0
    run_txn(2, 8'h9F, 0, 3, 1, 0);

    // send three bytes, collect four
    tx_data[0] = 8'h12; tx_data[1] = 8'h34; tx_data[2] = 8'h56;
    run_txn(1, 8'h03, 3, 4, 1, 0);
    bus_read(AD_WIN + 8'd1, v);
    check(v == 8'h34, "R4 send bytes kept below reply", v, 8'h34);

    // reply count zero
    tx_data[0] = 8'hAB; tx_data[1] = 8'hCD;
    run_txn(0, 8'h06, 2, 0, 1, 0);

    // writes while busy are ignored
    tx_data[0] = 8'h77;
    run_txn(3, 8'h0B, 1, 2, 0, 1);
    bus_read(AD_OPC, v);  check(v == 8'h0B, "R10 command reg kept", v, 8'h0B);
    bus_read(AD_TXC, v);  check(v == 8'h01, "R10 send count kept", v, 8'h01);
    bus_read(AD_RXC, v);  check(v == 8'h02, "R10 reply count kept", v, 8'h02);
    bus_read(AD_CTRL, v); check(v[5:4] == 2'd3, "R10 CS field kept", v[5:4], 3);
    bus_read(AD_WIN, v);  check(v == 8'h77, "R10 store entry kept", v, 8'h77);

    // full store: 64 sent, 6 returned, last reply lands on the final index
    for (int i = 0; i < 64; i++) tx_data[i] = 8'(i * 5 + 1);
    run_txn(1, 8'h02, 64, 6, 1, 0);
    bus_read(8'(AD_WIN + DEPTH - 1), v);
    check(v == slave_byte(70), "R4 last store index", v, slave_byte(70));

    // data port pointer and clear
    bus_write(AD_WIN + 8'd0, 8'h11);
    bus_write(AD_WIN + 8'd1, 8'h22);
    bus_write(AD_WIN + 8'd2, 8'h33);
    bus_write(AD_CTRL, 8'h02);
    bus_read(AD_CTRL, v); check(v[1] == 1'b0, "R11 clear bit reads 0", v, 0);
    bus_read(AD_PORT, v); check(v == 8'h11, "R9 port read 0", v, 8'h11);
    bus_read(AD_PORT, v); check(v == 8'h22, "R9 port read 1", v, 8'h22);
    bus_read(AD_PORT, v); check(v == 8'h33, "R9 port read 2", v, 8'h33);
    bus_write(AD_CTRL, 8'h02);
    bus_read(AD_PORT, v); check(v == 8'h11, "R9 pointer cleared", v, 8'h11);

    finish_run();
  end
endmodule